// File: doc/BRIEF.md
# Transceiver Lane Reset and Clock-Recovery Control Registers

This block is the register front end for a multi-lane serial transceiver. A word-addressed bus with separate write and read strobes reaches a small set of 32-bit words. These words drive per-lane reset levels, per-lane serial loopback, and per-lane clock-recovery lock-mode controls. Reads return live per-lane lock status and the ready flags of an external reset sequencer.

Resets can be raised in two ways. In automatic mode, a write to the trigger word sends a one-cycle request to the external sequencer, together with a copy of the lane enable mask. The sequencer then drives its own per-lane reset lines and reports ready. In manual mode, level bits stay set until software clears them. The same lane enable mask gates both kinds.

A small state machine issues the request pulse. It rests in `TRG_IDLE`. A trigger write with at least one request bit set moves it to `TRG_FIRE` (transition *arm*). It stays in `TRG_FIRE` while further such writes arrive (transition *re-arm*). Otherwise it returns to `TRG_IDLE` (transition *drain*). The request lines are high only in `TRG_FIRE`.

Top module: `xcvr_rst_csr`

## Requirements
- R1: The lane enable mask at word 0x41 resets to ones on every lane and is read/write. Bits at or above the lane count NUM_CH read as 0 and have no effect.
- R2: Writing word 0x42 with bit 0 set raises `seq_tx_req`, and with bit 1 set raises `seq_rx_req`. The request is high for exactly the one cycle after the write. `seq_req_mask` equals the lane enable mask as it stood at the write. A write of 0 to those bits raises no request.
- R3: Reading word 0x42 returns the sequencer TX ready flag in bit 0, the RX ready flag in bit 1, and 0 elsewhere. It never returns the written value.
- R4: Word 0x44 holds three manual levels: bit 1 is lane TX digital reset, bit 2 is RX analog reset and bit 3 is RX digital reset. Each stays set until a write clears it, and each reads back in its own position.
- R5: Bit 0 and bits 31:4 of word 0x44 are ignored on write and read as 0.
- R6: For each lane n, `tx_dig_rst[n]` = mask[n] AND (manual TX bit OR `seq_tx_rst[n]`). `rx_dig_rst[n]` = mask[n] AND (manual RX digital bit OR `seq_rx_rst[n]`). `rx_ana_rst[n]` = mask[n] AND the manual RX analog bit. These outputs follow their inputs in the same cycle.
- R7: Word 0x61 is read/write. Bit n drives `serial_lpbk[n]`.
- R8: Words 0x64 and 0x65 are read/write. Bit n drives `cdr_lock_data[n]` and `cdr_lock_ref[n]` respectively.
- R9: Words 0x66 and 0x67 return `cdr_locked_data` and `cdr_locked_ref` as sampled at the read. Writes to these words change nothing.
- R10: `rdata` is registered and shows the addressed word in the cycle after `rd_en`. A read in the same cycle as a write returns the old value. `rdata` is 0 after a read of an unmapped word and in any cycle not following a read. Writes to unmapped words change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd_en |
| seq_tx_req | output | 1 | One-cycle TX reset request to the sequencer |
| seq_rx_req | output | 1 | One-cycle RX reset request to the sequencer |
| seq_req_mask | output | NUM_CH | Lane mask snapshot carried with a request |
| seq_tx_ready | input | 1 | Sequencer TX ready flag |
| seq_rx_ready | input | 1 | Sequencer RX ready flag |
| seq_tx_rst | input | NUM_CH | Sequencer per-lane TX digital reset |
| seq_rx_rst | input | NUM_CH | Sequencer per-lane RX digital reset |
| tx_dig_rst | output | NUM_CH | Per-lane TX digital reset |
| rx_ana_rst | output | NUM_CH | Per-lane RX analog reset |
| rx_dig_rst | output | NUM_CH | Per-lane RX digital reset |
| serial_lpbk | output | NUM_CH | Per-lane serial loopback enable |
| cdr_lock_data | output | NUM_CH | Per-lane force lock-to-data |
| cdr_lock_ref | output | NUM_CH | Per-lane force lock-to-reference |
| cdr_locked_data | input | NUM_CH | Per-lane locked-to-data status |
| cdr_locked_ref | input | NUM_CH | Per-lane locked-to-reference status |

## Verification
Three groups of results fall due at different times. Read data and request pulses come one clock after the strobe that causes them. Control outputs such as loopback and lock mode follow a write on the next edge. The reset outputs also respond within the same cycle to the sequencer's reset inputs.

The bench model keeps to this timing. At each rising edge it computes the read data and request pulses that the edge produces, and only then applies that edge's writes to its own copies of the registers. Inputs change one nanosecond after the edge. Every output is compared at the falling edge, by which time both the registered values and the combinational reset gating have settled.

// File: rtl/xcvr_csr_pkg.sv
package xcvr_csr_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] W_LANE_EN  = 8'h41;
    localparam logic [ADDR_W-1:0] W_TRIGGER  = 8'h42;
    localparam logic [ADDR_W-1:0] W_MANUAL   = 8'h44;
    localparam logic [ADDR_W-1:0] W_LOOPBACK = 8'h61;
    localparam logic [ADDR_W-1:0] W_LTD_CTL  = 8'h64;
    localparam logic [ADDR_W-1:0] W_LTR_CTL  = 8'h65;
    localparam logic [ADDR_W-1:0] W_LTD_STS  = 8'h66;
    localparam logic [ADDR_W-1:0] W_LTR_STS  = 8'h67;

    localparam int MAN_TXD = 1;
    localparam int MAN_RXA = 2;
    localparam int MAN_RXD = 3;

    typedef enum logic {
        TRG_IDLE,
        TRG_FIRE
    } trg_state_e;
endpackage

// File: rtl/csr_regs.sv
module csr_regs
    import xcvr_csr_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_CH-1:0]    wlane,
    input  logic [2:0]           wman,
    output logic [NUM_CH-1:0]    lane_en,
    output logic                 man_txd,
    output logic                 man_rxa,
    output logic                 man_rxd,
    output logic [NUM_CH-1:0]    lpbk,
    output logic [NUM_CH-1:0]    ltd,
    output logic [NUM_CH-1:0]    ltr
);
    localparam logic [NUM_CH-1:0] LANES_ON = {NUM_CH{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_en <= LANES_ON;
            man_txd <= 1'b0;
            man_rxa <= 1'b0;
            man_rxd <= 1'b0;
            lpbk    <= '0;
            ltd     <= '0;
            ltr     <= '0;
        end else if (wr_en) begin
            unique case (addr)
                W_LANE_EN:  lane_en <= wlane;
                W_MANUAL: begin
                    man_txd <= wman[0];
                    man_rxa <= wman[1];
                    man_rxd <= wman[2];
                end
                W_LOOPBACK: lpbk <= wlane;
                W_LTD_CTL:  ltd  <= wlane;
                W_LTR_CTL:  ltr  <= wlane;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/csr_trig.sv
module csr_trig
    import xcvr_csr_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [1:0]           wbits,
    input  logic [NUM_CH-1:0]    lane_en,
    output logic                 tx_req,
    output logic                 rx_req,
    output logic [NUM_CH-1:0]    req_mask
);
    trg_state_e        state_q, state_d;
    logic              want_tx_q, want_rx_q;
    logic [NUM_CH-1:0] snap_q;
    logic              arm;

    assign arm = wr_en && (addr == W_TRIGGER) && (wbits != 2'b00);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRG_IDLE: state_d = arm ? TRG_FIRE : TRG_IDLE;
            TRG_FIRE: state_d = arm ? TRG_FIRE : TRG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= TRG_IDLE;
            want_tx_q <= 1'b0;
            want_rx_q <= 1'b0;
            snap_q    <= '0;
        end else begin
            state_q <= state_d;
            if (arm) begin
                want_tx_q <= wbits[0];
                want_rx_q <= wbits[1];
                snap_q    <= lane_en;
            end
        end
    end

    always_comb begin
        tx_req   = 1'b0;
        rx_req   = 1'b0;
        req_mask = '0;
        unique case (state_q)
            TRG_IDLE: ;
            TRG_FIRE: begin
                tx_req   = want_tx_q;
                rx_req   = want_rx_q;
                req_mask = snap_q;
            end
        endcase
    end
endmodule

// File: rtl/csr_rst_gate.sv
module csr_rst_gate #(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0] lane_en,
    input  logic              man_txd,
    input  logic              man_rxa,
    input  logic              man_rxd,
    input  logic [NUM_CH-1:0] seq_tx_rst,
    input  logic [NUM_CH-1:0] seq_rx_rst,
    output logic [NUM_CH-1:0] tx_dig_rst,
    output logic [NUM_CH-1:0] rx_ana_rst,
    output logic [NUM_CH-1:0] rx_dig_rst
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        assign tx_dig_rst[ch] = lane_en[ch] & (man_txd | seq_tx_rst[ch]);
        assign rx_ana_rst[ch] = lane_en[ch] & man_rxa;
        assign rx_dig_rst[ch] = lane_en[ch] & (man_rxd | seq_rx_rst[ch]);
    end
endmodule

// File: rtl/csr_rdmux.sv
module csr_rdmux
    import xcvr_csr_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_CH-1:0]    lane_en,
    input  logic                 man_txd,
    input  logic                 man_rxa,
    input  logic                 man_rxd,
    input  logic [NUM_CH-1:0]    lpbk,
    input  logic [NUM_CH-1:0]    ltd,
    input  logic [NUM_CH-1:0]    ltr,
    input  logic [NUM_CH-1:0]    sts_ltd,
    input  logic [NUM_CH-1:0]    sts_ltr,
    input  logic                 tx_ready,
    input  logic                 rx_ready,
    output logic [DATA_W-1:0]    rdata
);
    function automatic logic [DATA_W-1:0] widen(input logic [NUM_CH-1:0] v);
        logic [DATA_W-1:0] w;
        w = '0;
        w[NUM_CH-1:0] = v;
        return w;
    endfunction

    logic [DATA_W-1:0] word;

    always_comb begin
        word = '0;
        unique case (addr)
            W_LANE_EN:  word = widen(lane_en);
            W_TRIGGER: begin
                word[0] = tx_ready;
                word[1] = rx_ready;
            end
            W_MANUAL: begin
                word[MAN_TXD] = man_txd;
                word[MAN_RXA] = man_rxa;
                word[MAN_RXD] = man_rxd;
            end
            W_LOOPBACK: word = widen(lpbk);
            W_LTD_CTL:  word = widen(ltd);
            W_LTR_CTL:  word = widen(ltr);
            W_LTD_STS:  word = widen(sts_ltd);
            W_LTR_STS:  word = widen(sts_ltr);
            default:    word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_en ? word : '0;
    end
endmodule

// File: rtl/xcvr_rst_csr.sv
module xcvr_rst_csr
    import xcvr_csr_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic                 seq_tx_req,
    output logic                 seq_rx_req,
    output logic [NUM_CH-1:0]    seq_req_mask,
    input  logic                 seq_tx_ready,
    input  logic                 seq_rx_ready,
    input  logic [NUM_CH-1:0]    seq_tx_rst,
    input  logic [NUM_CH-1:0]    seq_rx_rst,
    output logic [NUM_CH-1:0]    tx_dig_rst,
    output logic [NUM_CH-1:0]    rx_ana_rst,
    output logic [NUM_CH-1:0]    rx_dig_rst,
    output logic [NUM_CH-1:0]    serial_lpbk,
    output logic [NUM_CH-1:0]    cdr_lock_data,
    output logic [NUM_CH-1:0]    cdr_lock_ref,
    input  logic [NUM_CH-1:0]    cdr_locked_data,
    input  logic [NUM_CH-1:0]    cdr_locked_ref
);
    logic [NUM_CH-1:0] lane_en;
    logic              man_txd, man_rxa, man_rxd;

    csr_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wlane   (wdata[NUM_CH-1:0]),
        .wman    (wdata[MAN_RXD:MAN_TXD]),
        .lane_en (lane_en),
        .man_txd (man_txd),
        .man_rxa (man_rxa),
        .man_rxd (man_rxd),
        .lpbk    (serial_lpbk),
        .ltd     (cdr_lock_data),
        .ltr     (cdr_lock_ref)
    );

    csr_trig #(.NUM_CH(NUM_CH)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wbits    (wdata[1:0]),
        .lane_en  (lane_en),
        .tx_req   (seq_tx_req),
        .rx_req   (seq_rx_req),
        .req_mask (seq_req_mask)
    );

    csr_rst_gate #(.NUM_CH(NUM_CH)) u_gate (
        .lane_en    (lane_en),
        .man_txd    (man_txd),
        .man_rxa    (man_rxa),
        .man_rxd    (man_rxd),
        .seq_tx_rst (seq_tx_rst),
        .seq_rx_rst (seq_rx_rst),
        .tx_dig_rst (tx_dig_rst),
        .rx_ana_rst (rx_ana_rst),
        .rx_dig_rst (rx_dig_rst)
    );

    csr_rdmux #(.NUM_CH(NUM_CH)) u_rdmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .addr     (addr),
        .lane_en  (lane_en),
        .man_txd  (man_txd),
        .man_rxa  (man_rxa),
        .man_rxd  (man_rxd),
        .lpbk     (serial_lpbk),
        .ltd      (cdr_lock_data),
        .ltr      (cdr_lock_ref),
        .sts_ltd  (cdr_locked_data),
        .sts_ltr  (cdr_locked_ref),
        .tx_ready (seq_tx_ready),
        .rx_ready (seq_rx_ready),
        .rdata    (rdata)
    );
endmodule

// File: rtl/xcvr_rst_csr_chk.sv
module xcvr_rst_csr_chk
    import xcvr_csr_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [DATA_W-1:0]    wdata,
    input logic [DATA_W-1:0]    rdata,
    input logic [NUM_CH-1:0]    lane_en,
    input logic                 seq_tx_req,
    input logic                 seq_rx_req,
    input logic [NUM_CH-1:0]    seq_req_mask,
    input logic [NUM_CH-1:0]    tx_dig_rst,
    input logic [NUM_CH-1:0]    rx_ana_rst,
    input logic [NUM_CH-1:0]    rx_dig_rst
);
    logic mapped;
    assign mapped = (addr == W_LANE_EN) || (addr == W_TRIGGER) || (addr == W_MANUAL) ||
                    (addr == W_LOOPBACK) || (addr == W_LTD_CTL) || (addr == W_LTR_CTL) ||
                    (addr == W_LTD_STS) || (addr == W_LTR_STS);

    // R2
    tx_req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_tx_req |-> $past(wr_en && (addr == W_TRIGGER) && wdata[0]));

    // R2
    rx_req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_rx_req |-> $past(wr_en && (addr == W_TRIGGER) && wdata[1]));

    // R2
    req_snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_tx_req || seq_rx_req) |-> (seq_req_mask == $past(lane_en)));

    // R6
    lane_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_dig_rst | rx_ana_rst | rx_dig_rst) & ~lane_en) == '0);

    // R3
    trig_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && (addr == W_TRIGGER)) |-> (rdata[DATA_W-1:2] == '0));

    // R10
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && !mapped) |-> (rdata == '0));
endmodule

bind xcvr_rst_csr xcvr_rst_csr_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr         (addr),
    .wdata        (wdata),
    .rdata        (rdata),
    .lane_en      (lane_en),
    .seq_tx_req   (seq_tx_req),
    .seq_rx_req   (seq_rx_req),
    .seq_req_mask (seq_req_mask),
    .tx_dig_rst   (tx_dig_rst),
    .rx_ana_rst   (rx_ana_rst),
    .rx_dig_rst   (rx_dig_rst)
);

// File: tb/xcvr_rst_csr_bench.sv
`timescale 1ns/1ps
module xcvr_rst_csr_bench;
    localparam int NCH = 4;
    localparam logic [31:0] CHM = 32'h0000_000F;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]      addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            seq_tx_req, seq_rx_req;
    logic [NCH-1:0]  seq_req_mask;
    logic            seq_tx_ready = 1'b0, seq_rx_ready = 1'b0;
    logic [NCH-1:0]  seq_tx_rst = '0, seq_rx_rst = '0;
    logic [NCH-1:0]  tx_dig_rst, rx_ana_rst, rx_dig_rst;
    logic [NCH-1:0]  serial_lpbk, cdr_lock_data, cdr_lock_ref;
    logic [NCH-1:0]  cdr_locked_data = '0, cdr_locked_ref = '0;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    xcvr_rst_csr #(.NUM_CH(NCH)) u_xcvr_rst_csr (.*);

    // reference model state
    logic [31:0] m_mask, m_man, m_lpbk, m_ltd, m_ltr;
    logic [31:0] e_rdata;
    logic        e_txr, e_rxr;
    logic [31:0] e_rmask;
    string       rd_tag = "R10";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask = CHM; m_man = 0; m_lpbk = 0; m_ltd = 0; m_ltr = 0;
            e_rdata = 0; e_txr = 0; e_rxr = 0; e_rmask = 0; rd_tag = "R10";
        end else begin
            e_txr = wr_en && addr == 8'h42 && wdata[0];
            e_rxr = wr_en && addr == 8'h42 && wdata[1];
            e_rmask = m_mask;
            e_rdata = 0;
            rd_tag = "R10";
            if (rd_en) begin
                case (addr)
                    8'h41: begin e_rdata = m_mask; rd_tag = "R1"; end
                    8'h42: begin e_rdata = {30'd0, seq_rx_ready, seq_tx_ready}; rd_tag = "R3"; end
                    8'h44: begin e_rdata = m_man; rd_tag = "R4,R5"; end
                    8'h61: begin e_rdata = m_lpbk; rd_tag = "R7"; end
                    8'h64, 8'h65: begin e_rdata = (addr == 8'h64) ? m_ltd : m_ltr; rd_tag = "R8"; end
                    8'h66: begin e_rdata = 32'(cdr_locked_data); rd_tag = "R9"; end
                    8'h67: begin e_rdata = 32'(cdr_locked_ref); rd_tag = "R9"; end
                    default: e_rdata = 0;
                endcase
            end
            if (wr_en) begin
                case (addr)
                    8'h41: m_mask = wdata & CHM;
                    8'h44: m_man  = wdata & 32'hE;
                    8'h61: m_lpbk = wdata & CHM;
                    8'h64: m_ltd  = wdata & CHM;
                    8'h65: m_ltr  = wdata & CHM;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every output at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [31:0] etx, erxa, erxd;
            etx  = m_mask & ((m_man[1] ? CHM : 0) | 32'(seq_tx_rst));
            erxa = m_mask & (m_man[2] ? CHM : 0);
            erxd = m_mask & ((m_man[3] ? CHM : 0) | 32'(seq_rx_rst));
            chk(rd_tag, rdata, e_rdata);
            chk("R2 tx_req", 32'(seq_tx_req), 32'(e_txr));
            chk("R2 rx_req", 32'(seq_rx_req), 32'(e_rxr));
            if (e_txr || e_rxr) chk("R2 mask", 32'(seq_req_mask), e_rmask);
            chk("R6 tx_dig", 32'(tx_dig_rst), etx);
            chk("R6 rx_ana", 32'(rx_ana_rst), erxa);
            chk("R6 rx_dig", 32'(rx_dig_rst), erxd);
            chk("R7 lpbk", 32'(serial_lpbk), m_lpbk);
            chk("R8 ltd", 32'(cdr_lock_data), m_ltd);
            chk("R8 ltr", 32'(cdr_lock_ref), m_ltr);
        end
    end

    task automatic op(input logic w, input logic r, input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = w; rd_en = r; addr = a; wdata = d;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // reset state: R1 mask all ones, others zero
        op(0, 1, 8'h41, 0);
        op(0, 1, 8'h44, 0);
        op(0, 1, 8'h61, 0);
        op(0, 1, 8'h64, 0);
        // R1 bits above lane count ignored
        op(1, 0, 8'h41, 32'hFFFF_FFFF);
        op(0, 1, 8'h41, 0);
        op(1, 0, 8'h41, 32'h0000_0005);
        // R2 both triggers, then a write of zero
        op(1, 0, 8'h42, 32'h3);
        op(1, 0, 8'h42, 32'h0);
        op(1, 0, 8'h42, 32'h1);
        op(1, 0, 8'h42, 32'h2);
        // R3 status readback with ready flags
        seq_tx_ready = 1'b1;
        op(0, 1, 8'h42, 0);
        seq_rx_ready = 1'b1; seq_tx_ready = 1'b0;
        op(0, 1, 8'h42, 0);
        // R4, R6 manual levels and sequencer resets
        seq_tx_rst = 4'b1010; seq_rx_rst = 4'b0110;
        op(1, 0, 8'h44, 32'h0000_000E);
        op(0, 1, 8'h44, 0);
        op(0, 0, 8'h00, 0);
        op(1, 0, 8'h41, 32'hF);
        op(1, 0, 8'h44, 32'h0);
        // R5 reserved bits ignored
        op(1, 0, 8'h44, 32'hFFFF_FFF1);
        op(0, 1, 8'h44, 0);
        // R7, R8 controls
        op(1, 0, 8'h61, 32'h9);
        op(1, 1, 8'h64, 32'h6);
        op(1, 1, 8'h65, 32'hC);
        op(0, 1, 8'h65, 0);
        // R9 status words, writes ignored
        cdr_locked_data = 4'b0011; cdr_locked_ref = 4'b1100;
        op(1, 0, 8'h66, 32'hFFFF_FFFF);
        op(0, 1, 8'h66, 0);
        op(0, 1, 8'h67, 0);
        // R10 unmapped
        op(1, 0, 8'h43, 32'hFFFF_FFFF);
        op(0, 1, 8'h43, 0);
        op(0, 1, 8'h41, 0);
        // randomised traffic
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a;
            int sel;
            sel = $urandom_range(0, 9);
            case (sel)
                0: a = 8'h41; 1: a = 8'h42; 2: a = 8'h44; 3: a = 8'h61;
                4: a = 8'h64; 5: a = 8'h65; 6: a = 8'h66; 7: a = 8'h67;
                default: a = 8'($urandom);
            endcase
            seq_tx_ready = 1'($urandom); seq_rx_ready = 1'($urandom);
            seq_tx_rst = 4'($urandom); seq_rx_rst = 4'($urandom);
            cdr_locked_data = 4'($urandom); cdr_locked_ref = 4'($urandom);
            op(1'($urandom), 1'($urandom), a, $urandom);
        end
        op(0, 0, 8'h00, 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        summary();
    end
endmodule